// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small processor core built around a single accumulator. It runs one instruction at a time through a fetch phase and an execute phase. All traffic goes over one word-addressed memory port that has an address, write data, read data, a read strobe and a write strobe. Internally the core keeps a program counter, an instruction register, a memory address register, a memory buffer register and the accumulator. Every memory access, whether it is an instruction fetch or an operand transfer, is staged through the address register and the buffer register.

An instruction is one 16-bit word: a 4-bit operation code followed by a 12-bit direct address. The core can load the accumulator from memory, add a memory word into it, store it to memory, and halt. Two status outputs report the current phase and whether the core has halted. The memory is expected to answer a read one clock after the strobe. A surrounding system fills memory, releases reset, and waits for the halted flag.

Top module: `acc_core_top`

## Requirements
- R1: While reset is high and in the first cycle after it, the core drives both strobes low, reports the fetch phase (`phase_exec` = 0) and reports not halted. The first read it issues is at address 0x300, which is the default of the start-address parameter.
- R2: Each fetch reads the word at the program counter through the address and buffer registers into the instruction register, and then advances the program counter by one. Successive instructions are therefore fetched from consecutive addresses.
- R3: Bits 15:12 of an instruction select the operation and bits 11:0 give the operand address. Every address from 0x000 to 0xFFF can be reached.
- R4: Operation 0x1 replaces the accumulator with the memory word at the operand address.
- R5: Operation 0x5 adds the memory word at the operand address to the accumulator, modulo 2^16, with no carry or overflow kept.
- R6: Operation 0x2 writes the accumulator to the operand address and leaves the accumulator unchanged.
- R7: Operation 0x0 raises `halted`, which then stays high until reset. From that point no read or write strobe is issued and no further instruction is fetched.
- R8: Any other operation code does nothing. It leaves memory and the accumulator untouched and takes exactly one execute cycle.
- R9: A read strobe is followed by capture of `mem_rdata` on the next cycle. The cycle cost of an instruction is 7 for load and add, 5 for store, 4 for an undefined code, and 4 cycles to reach the halted state.
- R10: Each instruction spends exactly three cycles in the fetch phase (`phase_exec` = 0). All of its remaining cycles, and the halted state, report the execute phase (`phase_exec` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| phase_exec | output | 1 | 0 during fetch, 1 during execute or halt |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Two things coincide in the first execute cycle. The instruction register takes the fetched word out of the buffer register, and a store in the same cycle overwrites that buffer register with the accumulator. Running add immediately followed by store on the same location provokes this: if either transfer is lost, the wrong instruction executes or a stale value is written. The outcome is judged from the stored memory word, from the cycle count to halt, and from the fetch addresses staying consecutive. The sweep over operand pairs also makes sure that wraparound at 0xFFFF and at the sign boundary lands in the accumulator.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned OPC_W = 4;

    typedef logic [OPC_W-1:0] opc_t;

    localparam opc_t OPC_HALT  = 4'h0;
    localparam opc_t OPC_LOAD  = 4'h1;
    localparam opc_t OPC_STORE = 4'h2;
    localparam opc_t OPC_ADD   = 4'h5;

    typedef enum logic [2:0] {
        K_HALT,
        K_LOAD,
        K_ADD,
        K_STORE,
        K_NOP
    } kind_e;

    typedef enum logic [3:0] {
        ST_F_ADDR,
        ST_F_READ,
        ST_F_CAPT,
        ST_X_DEC,
        ST_X_READ,
        ST_X_CAPT,
        ST_X_ACC,
        ST_X_WRITE,
        ST_HALT
    } step_e;

    typedef struct packed {
        logic mar_pc;
        logic mar_opnd;
        logic pc_inc;
        logic mbr_mem;
        logic mbr_acc;
        logic ir_load;
        logic acc_load;
        logic acc_add;
        logic mem_rd;
        logic mem_wr;
    } ctl_t;

    function automatic kind_e decode_kind(input opc_t op);
        case (op)
            OPC_HALT:  return K_HALT;
            OPC_LOAD:  return K_LOAD;
            OPC_ADD:   return K_ADD;
            OPC_STORE: return K_STORE;
            default:   return K_NOP;
        endcase
    endfunction

    function automatic logic in_fetch(input step_e s);
        return (s == ST_F_ADDR) || (s == ST_F_READ) || (s == ST_F_CAPT);
    endfunction

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  opc_t mbr_op,
    input  opc_t ir_op,
    output ctl_t ctl,
    output logic phase_exec,
    output logic halted
);

    step_e state;
    step_e state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_F_ADDR;
        else     state <= state_nx;
    end

    always_comb begin
        ctl      = '0;
        state_nx = state;
        unique case (state)
            ST_F_ADDR: begin
                ctl.mar_pc = 1'b1;
                state_nx   = ST_F_READ;
            end
            ST_F_READ: begin
                ctl.mem_rd = 1'b1;
                ctl.pc_inc = 1'b1;
                state_nx   = ST_F_CAPT;
            end
            ST_F_CAPT: begin
                ctl.mbr_mem = 1'b1;
                state_nx    = ST_X_DEC;
            end
            ST_X_DEC: begin
                ctl.ir_load  = 1'b1;
                ctl.mar_opnd = 1'b1;
                unique case (decode_kind(mbr_op))
                    K_HALT:  state_nx = ST_HALT;
                    K_LOAD,
                    K_ADD:   state_nx = ST_X_READ;
                    K_STORE: begin
                        ctl.mbr_acc = 1'b1;
                        state_nx    = ST_X_WRITE;
                    end
                    default: state_nx = ST_F_ADDR;
                endcase
            end
            ST_X_READ: begin
                ctl.mem_rd = 1'b1;
                state_nx   = ST_X_CAPT;
            end
            ST_X_CAPT: begin
                ctl.mbr_mem = 1'b1;
                state_nx    = ST_X_ACC;
            end
            ST_X_ACC: begin
                if (decode_kind(ir_op) == K_ADD) ctl.acc_add  = 1'b1;
                else                             ctl.acc_load = 1'b1;
                state_nx = ST_F_ADDR;
            end
            ST_X_WRITE: begin
                ctl.mem_wr = 1'b1;
                state_nx   = ST_F_ADDR;
            end
            ST_HALT:  state_nx = ST_HALT;
            default:  state_nx = ST_F_ADDR;
        endcase
    end

    assign phase_exec = !in_fetch(state);
    assign halted     = (state == ST_HALT);

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        halted |-> !ctl.mem_rd && !ctl.mem_wr);

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_read_capture_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_rd |=> ctl.mbr_mem);

    assert_fetch_read_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.mar_pc |=> ctl.mem_rd && !phase_exec);

endmodule

// File: rtl/acc_dp.sv
module acc_dp
    import acc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h300
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output opc_t              mbr_op,
    output opc_t              ir_op
);

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= RESET_PC;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            acc <= '0;
        end else begin
            if (ctl.pc_inc)        pc  <= pc + ADDR_W'(1);
            if (ctl.mar_pc)        mar <= pc;
            else if (ctl.mar_opnd) mar <= mbr[ADDR_W-1:0];
            if (ctl.mbr_mem)       mbr <= mem_rdata;
            else if (ctl.mbr_acc)  mbr <= acc;
            if (ctl.ir_load)       ir  <= mbr;
            if (ctl.acc_load)      acc <= mbr;
            else if (ctl.acc_add)  acc <= acc + mbr;
        end
    end

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign mbr_op    = mbr[DATA_W-1 -: OPC_W];
    assign ir_op     = ir[DATA_W-1 -: OPC_W];

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_inc |=> pc == $past(pc) + ADDR_W'(1));

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ctl.pc_inc |=> $stable(pc));

    assert_ir_from_mbr_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.ir_load |=> ir == $past(mbr));

    assert_acc_load_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_load |=> acc == $past(mbr));

    assert_acc_sum_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.acc_add |=> acc == $past(acc) + $past(mbr));

    assert_store_data_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_wr |-> mem_wdata == acc);

endmodule

// File: rtl/acc_core_top.sv
module acc_core_top
    import acc_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter logic [DATA_W-OPC_W-1:0] RESET_PC = 12'h300
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [DATA_W-OPC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic                      phase_exec,
    output logic                      halted
);

    localparam int unsigned ADDR_W = DATA_W - OPC_W;

    ctl_t ctl;
    opc_t mbr_op;
    opc_t ir_op;

    acc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .mbr_op     (mbr_op),
        .ir_op      (ir_op),
        .ctl        (ctl),
        .phase_exec (phase_exec),
        .halted     (halted)
    );

    acc_dp #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mbr_op    (mbr_op),
        .ir_op     (ir_op)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

// File: tb/acc_core_top_tb_top.sv
module acc_core_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd;
    logic        mem_wr;
    logic        phase_exec;
    logic        halted;

    logic        tb_we = 1'b0;
    logic [11:0] tb_waddr = '0;
    logic [15:0] tb_wdata = '0;
    logic [15:0] mem [0:4095];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int          run_cyc;
    int          fetch_cyc;
    int          fetch_idx;
    int          seq_err;
    int          quiet_err;
    logic [11:0] first_fetch;

    always #10 clk = ~clk;

    acc_core_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .phase_exec (phase_exec),
        .halted     (halted)
    );

    always @(posedge clk) begin
        if (mem_wr)     mem[mem_addr] <= mem_wdata;
        else if (tb_we) mem[tb_waddr] <= tb_wdata;
        if (mem_rd)     mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (rst) begin
            run_cyc     <= 0;
            fetch_cyc   <= 0;
            fetch_idx   <= 0;
            seq_err     <= 0;
            quiet_err   <= 0;
            first_fetch <= '1;
        end else begin
            if (!halted) run_cyc <= run_cyc + 1;
            if (!halted && !phase_exec) fetch_cyc <= fetch_cyc + 1;
            if (mem_rd && !phase_exec) begin
                if (fetch_idx == 0) first_fetch <= mem_addr;
                if (mem_addr != 12'(12'h300 + fetch_idx)) seq_err <= seq_err + 1;
                fetch_idx <= fetch_idx + 1;
            end
            if (halted && (mem_rd || mem_wr)) quiet_err <= quiet_err + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        @(posedge clk);
        #1;
        tb_we    = 1'b1;
        tb_waddr = a;
        tb_wdata = d;
        @(posedge clk);
        #1;
        tb_we = 1'b0;
    endtask

    task automatic hold_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic run_prog();
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int k = 0; k < 400 && !halted; k++) @(negedge clk);
        repeat (10) @(negedge clk);
        #1;
    endtask

    function automatic logic [15:0] pick(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h0002;
            3: return 16'h7FFF;
            4: return 16'h8000;
            5: return 16'hFFFF;
            6: return 16'h1234;
            default: return 16'hABCD;
        endcase
    endfunction

    initial begin
        hold_reset();
        @(negedge clk);
        check(phase_exec == 1'b0, "R1", "phase in reset", 32'(phase_exec), 0);
        check(halted == 1'b0, "R1", "halted in reset", 32'(halted), 0);
        check(!mem_rd && !mem_wr, "R1", "strobes in reset", 32'({mem_rd, mem_wr}), 0);

        // Example program: add then store on the same location
        poke(12'h300, 16'h1940);
        poke(12'h301, 16'h5941);
        poke(12'h302, 16'h2941);
        poke(12'h303, 16'h0000);
        poke(12'h940, 16'h0003);
        poke(12'h941, 16'h0002);
        run_prog();
        check(first_fetch == 12'h300, "R1", "first fetch address", 32'(first_fetch), 32'h300);
        check(mem[12'h941] == 16'h0005, "R6", "stored sum", 32'(mem[12'h941]), 5);
        check(mem[12'h940] == 16'h0003, "R4", "source untouched", 32'(mem[12'h940]), 3);
        check(run_cyc == 23, "R9", "cycles load+add+store+halt", 32'(run_cyc), 23);
        check(fetch_cyc == 12, "R10", "fetch-phase cycles", 32'(fetch_cyc), 12);
        check(seq_err == 0 && fetch_idx == 4, "R2", "sequential fetches", 32'(fetch_idx), 4);
        check(halted == 1'b1 && phase_exec == 1'b1, "R7", "halted flag", 32'({halted, phase_exec}), 3);
        check(quiet_err == 0, "R7", "strobes after halt", 32'(quiet_err), 0);

        // Sweep operand pairs for load, add with wraparound, store
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [11:0] dst;
                logic [15:0] expv;
                dst  = 12'(12'h800 + i * 8 + j);
                expv = pick(i) + pick(j);
                hold_reset();
                poke(12'h300, 16'h1FFF);
                poke(12'h301, 16'h5001);
                poke(12'h302, {4'h2, dst});
                poke(12'h303, 16'h0000);
                poke(12'hFFF, pick(i));
                poke(12'h001, pick(j));
                poke(dst, 16'hDEAD);
                run_prog();
                check(mem[dst] == expv, "R5", "wrapped sum", 32'(mem[dst]), 32'(expv));
                if (i == 7 && j == 7) begin
                    check(mem[12'hFFF] == pick(7), "R3", "address 0xFFF operand kept", 32'(mem[12'hFFF]), 32'(pick(7)));
                    check(run_cyc == 23, "R9", "sweep cycle count", 32'(run_cyc), 23);
                end
            end
        end

        // Undefined operation codes act as one-cycle no-ops
        for (int op = 3; op < 16; op++) begin
            if (op != 5) begin
                logic [15:0] xv;
                xv = 16'(16'h5A50 + op);
                hold_reset();
                poke(12'h300, 16'h1020);
                poke(12'h301, {4'(op), 12'h021});
                poke(12'h302, 16'h2022);
                poke(12'h303, 16'h0000);
                poke(12'h020, xv);
                poke(12'h021, 16'h1111);
                poke(12'h022, 16'h0000);
                run_prog();
                check(mem[12'h022] == xv, "R8", "accumulator kept across no-op", 32'(mem[12'h022]), 32'(xv));
                check(mem[12'h021] == 16'h1111, "R8", "no-op target untouched", 32'(mem[12'h021]), 32'h1111);
                check(run_cyc == 20, "R8", "no-op cycle cost", 32'(run_cyc), 20);
            end
        end

        // Halt as the first instruction: nothing after it runs
        hold_reset();
        poke(12'h300, 16'h0000);
        poke(12'h301, 16'h2050);
        poke(12'h050, 16'hBEEF);
        run_prog();
        check(run_cyc == 4, "R9", "halt cycle cost", 32'(run_cyc), 4);
        check(fetch_idx == 1, "R7", "single fetch before halt", 32'(fetch_idx), 1);
        check(mem[12'h050] == 16'hBEEF, "R7", "store after halt not run", 32'(mem[12'h050]), 32'hBEEF);
        check(quiet_err == 0 && halted == 1'b1, "R7", "quiet while halted", 32'(quiet_err), 0);

        // Store leaves the accumulator intact: store twice after one load
        hold_reset();
        poke(12'h300, 16'h1060);
        poke(12'h301, 16'h2061);
        poke(12'h302, 16'h2062);
        poke(12'h303, 16'h0000);
        poke(12'h060, 16'h4321);
        poke(12'h061, 16'h0000);
        poke(12'h062, 16'h0000);
        run_prog();
        check(mem[12'h061] == 16'h4321, "R4", "loaded value stored", 32'(mem[12'h061]), 32'h4321);
        check(mem[12'h062] == 16'h4321, "R6", "accumulator kept after store", 32'(mem[12'h062]), 32'h4321);
        check(run_cyc == 21, "R9", "load+store+store+halt cycles", 32'(run_cyc), 21);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

endmodule